// File: doc/BRIEF.md
# MAC Configuration Register Bank

This block is the host-facing register file of an Ethernet MAC. A processor-neutral bus carries a 10-bit address, 32-bit write data, a 2-bit opcode, a request strobe and a select line. When the select line is high the access goes to an external PHY-management port. When it is low the access goes to the internal configuration words. Each word is decoded over a wide address range whose low bits are ignored. The words hold the receiver, transmitter, flow-control, speed, management, unicast-address, address-table and filter-mode settings, and each has its own reset default.

The receive and transmit datapaths never see the host copy of their settings directly. Each path has a shadow copy that is refreshed only on a clock edge where that path's inter-frame-gap strobe is high, so a frame in flight never sees its settings change. The two reset bits bypass the shadow and act on the cycle after they are written. The speed indicator outputs, the management settings, the unicast address, the promiscuous flag and the address table are driven straight from the host copy.

Top module: `mac_cfg_regbank`

## Requirements
- R1: A register access is `host_req`=1 with `host_phy_sel`=0; `host_op[1]`=0 writes and `host_op[1]`=1 reads. Every address within a range reaches the same word: 0x200-0x23F receiver word A, 0x240-0x27F receiver word B, 0x280-0x2BF transmitter, 0x2C0-0x2FF flow control, 0x300-0x31F speed, 0x340-0x37F management. Read data appears on `host_rdata` after the clock edge that takes the read and holds until the next read.
- R2: After reset, receiver word B reads 0x10000000, transmitter reads 0x10000000, flow control reads 0x60000000, speed reads 0x80000000, management and receiver word A read 0, `ucast_addr` equals the UCAST_DEFAULT parameter and `promisc` is 1.
- R3: Receiver word B keeps bits 15-0 (upper 16 bits of the pause source address, word A holding the lower 32) and bits 31-25 (31 reset, 30 jumbo, 29 in-band FCS, 28 receive enable, 27 VLAN, 26 half duplex, 25 length/type check disable). Other bits read 0 and ignore writes. `rx_cfg` is {pause address[47:0], bit25, bit26, bit27, bit28, bit29, bit30} from bit 53 down to bit 0.
- R4: The transmitter word keeps bits 31-25 (31 reset, 30 jumbo, 29 in-band FCS, 28 transmit enable, 27 VLAN, 26 half duplex, 25 IFG adjust). Other bits read 0. `tx_cfg` is {bit25, bit26, bit27, bit28, bit29, bit30} from bit 5 down to bit 0.
- R5: Flow-control bit 29 enables pause on receive (`fc_rx_en`) and bit 30 on transmit (`fc_tx_en`). Speed bits 31-30 hold the speed code: 10 is 1000, 01 is 100, 00 is 10 Mbps. `speed_is_100` is 1 only for code 01, and `speed_is_10_100` is 1 only for codes 01 and 00. Both outputs follow the word on the cycle after a write.
- R6: Management bits 5-0 drive `mdio_div` and bit 6 drives `mdio_en`. Other bits read 0.
- R7: `rx_cfg` and `fc_rx_en` change only on a clock edge with `rx_ifg`=1, when they take the current host values. `tx_cfg` and `fc_tx_en` change only on an edge with `tx_ifg`=1, in the same way.
- R8: Receiver word B bit 31 drives `rx_reset` and transmitter bit 31 drives `tx_reset`, on the cycle after the write, without waiting for an inter-frame gap.
- R9: With `host_phy_sel`=1, `phy_req` follows `host_req`, and `phy_op`, `phy_addr` and `phy_wdata` carry the bus fields. No internal word changes. A read (`host_op[1]`=1) returns `phy_rdata` on `host_rdata`. With `host_phy_sel`=0, `phy_req` is 0.
- R10: The range 0x320-0x33F and all unmapped addresses (below 0x200, 0x3C0 and above) read 0 and ignore writes.
- R11: Table word A (0x388-0x38B) holds address bits 31-0. Table word B (0x38C-0x38F) holds address bits 47-32 in bits 15-0, the entry index in bits 17-16, and a read-not-write flag in bit 23. Writing word B with bit 23=0 stores {word B[15:0], word A} into the entry. With bit 23=1 it loads the entry back into words A and B. Bit 23 reads 0. The entries drive `tbl_addrs` (entry i at bits 48*i+47 to 48*i).
- R12: Unicast word A (0x380-0x383) holds bits 31-0 and word B (0x384-0x387) holds bits 47-32 in bits 15-0 of `ucast_addr`. Filter-mode bit 31 (0x390-0x3BF) drives `promisc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Access strobe |
| host_op | input | 2 | Opcode; bit 1 high means read |
| host_phy_sel | input | 1 | 1 routes the access to the PHY-management port |
| host_addr | input | 10 | Register address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, registered |
| phy_req | output | 1 | Access strobe to the PHY-management port |
| phy_op | output | 2 | Opcode to the PHY-management port |
| phy_addr | output | 10 | Address to the PHY-management port |
| phy_wdata | output | 32 | Write data to the PHY-management port |
| phy_rdata | input | 32 | Read data from the PHY-management port |
| rx_ifg | input | 1 | Receive path is between frames |
| tx_ifg | input | 1 | Transmit path is between frames |
| rx_cfg | output | 54 | Shadowed receive settings |
| tx_cfg | output | 6 | Shadowed transmit settings |
| fc_rx_en | output | 1 | Shadowed receive pause enable |
| fc_tx_en | output | 1 | Shadowed transmit pause enable |
| rx_reset | output | 1 | Receive path reset |
| tx_reset | output | 1 | Transmit path reset |
| speed_is_100 | output | 1 | Speed is 100 Mbps |
| speed_is_10_100 | output | 1 | Speed is 10 or 100 Mbps |
| mdio_div | output | 6 | Management clock divider |
| mdio_en | output | 1 | Management interface enable |
| ucast_addr | output | 48 | Unicast station address |
| promisc | output | 1 | Address filter bypass |
| tbl_addrs | output | TBL_DEPTH*48 | Address table entries |

## Verification
The assertions check on every cycle that a shadow holds its value on edges without its gap strobe and takes the host value on edges with it. They also check that PHY-routed and reserved-range accesses leave every word untouched, that a table read-back leaves the entries alone, that the reserved bits of receiver word B stay zero, and that a reset-bit write reaches its output on the next cycle. Only the bench scenarios can show the decoded range boundaries, the read masks and defaults of each word, the speed code mapping, and the table store and read-back order.

// File: rtl/mac_cfg_pkg.sv
package mac_cfg_pkg;

    localparam int ADDR_W  = 10;
    localparam int DATA_W  = 32;
    localparam int MAC_W   = 48;
    localparam int DIV_W   = 6;
    localparam int RXCFG_W = MAC_W + 6;
    localparam int TXCFG_W = 6;

    // shared bit positions of the receiver word B and the transmitter word
    localparam int B_RESET = 31;
    localparam int B_JUMBO = 30;
    localparam int B_FCS   = 29;
    localparam int B_EN    = 28;
    localparam int B_VLAN  = 27;
    localparam int B_HALF  = 26;
    localparam int B_MISC  = 25;

    localparam int FC_RX_BIT   = 29;
    localparam int FC_TX_BIT   = 30;
    localparam int PROMISC_BIT = 31;
    localparam int AT_RNW_BIT  = 23;
    localparam int AT_IDX_LSB  = 16;
    localparam int MDIO_EN_BIT = 6;

    localparam logic [1:0] SPD_1000 = 2'b10;
    localparam logic [1:0] SPD_100  = 2'b01;
    localparam logic [1:0] SPD_10   = 2'b00;

    localparam logic [DATA_W-1:0] RX1_MASK  = 32'hFE00_FFFF;
    localparam logic [DATA_W-1:0] TX_MASK   = 32'hFE00_0000;
    localparam logic [DATA_W-1:0] FC_MASK   = 32'h6000_0000;
    localparam logic [DATA_W-1:0] SPD_MASK  = 32'hC000_0000;
    localparam logic [DATA_W-1:0] MGMT_MASK = 32'h0000_007F;
    localparam logic [DATA_W-1:0] UC1_MASK  = 32'h0000_FFFF;
    localparam logic [DATA_W-1:0] AFM_MASK  = 32'h8000_0000;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_RXA, SEL_RXB, SEL_TX, SEL_FC, SEL_SPD, SEL_RSVD,
        SEL_MGMT, SEL_UCA, SEL_UCB, SEL_TBLA, SEL_TBLB, SEL_AFM
    } word_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] rxa;
        logic [DATA_W-1:0] rxb;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] fc;
        logic [DATA_W-1:0] spd;
        logic [DATA_W-1:0] mgmt;
        logic [DATA_W-1:0] uca;
        logic [DATA_W-1:0] ucb;
        logic [DATA_W-1:0] tbla;
        logic [DATA_W-1:0] tblb;
        logic [DATA_W-1:0] afm;
    } host_words_t;

endpackage

// File: rtl/mac_cfg_decode.sv
module mac_cfg_decode
    import mac_cfg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output word_sel_e         sel
);
    always_comb begin
        casez (addr)
            10'b1000??????: sel = SEL_RXA;
            10'b1001??????: sel = SEL_RXB;
            10'b1010??????: sel = SEL_TX;
            10'b1011??????: sel = SEL_FC;
            10'b11000?????: sel = SEL_SPD;
            10'b11001?????: sel = SEL_RSVD;
            10'b1101??????: sel = SEL_MGMT;
            10'b11100000??: sel = SEL_UCA;
            10'b11100001??: sel = SEL_UCB;
            10'b11100010??: sel = SEL_TBLA;
            10'b11100011??: sel = SEL_TBLB;
            10'b111001????: sel = SEL_AFM;
            10'b11101?????: sel = SEL_AFM;
            default:        sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/mac_cfg_hostregs.sv
module mac_cfg_hostregs
    import mac_cfg_pkg::*;
#(
    parameter int                TBL_DEPTH     = 4,
    parameter logic [MAC_W-1:0]  UCAST_DEFAULT = 48'h0200_0000_0001
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  word_sel_e                  sel,
    input  logic [DATA_W-1:0]          wdata,
    output host_words_t                words,
    output logic [DATA_W-1:0]          rd_word,
    output logic [TBL_DEPTH*MAC_W-1:0] tbl_flat
);
    localparam int IDX_W = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1;
    localparam logic [DATA_W-1:0] TBLB_MASK =
        32'h0000_FFFF | ((32'(TBL_DEPTH) - 32'd1) << AT_IDX_LSB);

    typedef struct packed {
        host_words_t                         w;
        logic [TBL_DEPTH-1:0][MAC_W-1:0]     tbl;
    } state_t;

    state_t           st_d, st_q;
    logic [IDX_W-1:0] idx_d;

    always_comb begin
        st_d  = st_q;
        idx_d = wdata[AT_IDX_LSB +: IDX_W];
        if (wr_en) begin
            case (sel)
                SEL_RXA:  st_d.w.rxa  = wdata;
                SEL_RXB:  st_d.w.rxb  = wdata & RX1_MASK;
                SEL_TX:   st_d.w.tx   = wdata & TX_MASK;
                SEL_FC:   st_d.w.fc   = wdata & FC_MASK;
                SEL_SPD:  st_d.w.spd  = wdata & SPD_MASK;
                SEL_MGMT: st_d.w.mgmt = wdata & MGMT_MASK;
                SEL_UCA:  st_d.w.uca  = wdata;
                SEL_UCB:  st_d.w.ucb  = wdata & UC1_MASK;
                SEL_AFM:  st_d.w.afm  = wdata & AFM_MASK;
                SEL_TBLA: st_d.w.tbla = wdata;
                SEL_TBLB: begin
                    st_d.w.tblb = wdata & TBLB_MASK;
                    if (wdata[AT_RNW_BIT]) begin
                        st_d.w.tbla        = st_q.tbl[idx_d][31:0];
                        st_d.w.tblb[15:0]  = st_q.tbl[idx_d][MAC_W-1:32];
                    end else begin
                        st_d.tbl[idx_d] = {wdata[15:0], st_q.w.tbla};
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.w.rxb  <= 32'h1000_0000;
            st_q.w.tx   <= 32'h1000_0000;
            st_q.w.fc   <= 32'h6000_0000;
            st_q.w.spd  <= {SPD_1000, 30'd0};
            st_q.w.uca  <= UCAST_DEFAULT[31:0];
            st_q.w.ucb  <= {16'd0, UCAST_DEFAULT[MAC_W-1:32]};
            st_q.w.afm  <= 32'h8000_0000;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (sel)
            SEL_RXA:  rd_word = st_q.w.rxa;
            SEL_RXB:  rd_word = st_q.w.rxb;
            SEL_TX:   rd_word = st_q.w.tx;
            SEL_FC:   rd_word = st_q.w.fc;
            SEL_SPD:  rd_word = st_q.w.spd;
            SEL_MGMT: rd_word = st_q.w.mgmt;
            SEL_UCA:  rd_word = st_q.w.uca;
            SEL_UCB:  rd_word = st_q.w.ucb;
            SEL_TBLA: rd_word = st_q.w.tbla;
            SEL_TBLB: rd_word = st_q.w.tblb;
            SEL_AFM:  rd_word = st_q.w.afm;
            default:  rd_word = '0;
        endcase
    end

    assign words    = st_q.w;
    assign tbl_flat = st_q.tbl;

    AST_RXB_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.w.rxb & ~RX1_MASK) == '0); // R3

    AST_RSVD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (sel == SEL_RSVD || sel == SEL_NONE) |=> $stable(st_q)); // R10

    AST_TBL_READBACK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && sel == SEL_TBLB && wdata[AT_RNW_BIT] |=> $stable(st_q.tbl)); // R11

endmodule

// File: rtl/mac_cfg_shadow.sv
module mac_cfg_shadow #(
    parameter int             W         = 8,
    parameter logic [W-1:0]   RESET_VAL = '0
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] src,
    output logic [W-1:0] shadow
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) sh_d = src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= RESET_VAL;
        else        sh_q <= sh_d;
    end

    assign shadow = sh_q;

    AST_SHADOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(sh_q)); // R7

    AST_SHADOW_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> sh_q == $past(src)); // R7

endmodule

// File: rtl/mac_cfg_regbank.sv
module mac_cfg_regbank
    import mac_cfg_pkg::*;
#(
    parameter int               TBL_DEPTH     = 4,
    parameter logic [MAC_W-1:0] UCAST_DEFAULT = 48'h0200_0000_0001
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_req,
    input  logic [1:0]                 host_op,
    input  logic                       host_phy_sel,
    input  logic [ADDR_W-1:0]          host_addr,
    input  logic [DATA_W-1:0]          host_wdata,
    output logic [DATA_W-1:0]          host_rdata,
    output logic                       phy_req,
    output logic [1:0]                 phy_op,
    output logic [ADDR_W-1:0]          phy_addr,
    output logic [DATA_W-1:0]          phy_wdata,
    input  logic [DATA_W-1:0]          phy_rdata,
    input  logic                       rx_ifg,
    input  logic                       tx_ifg,
    output logic [RXCFG_W-1:0]         rx_cfg,
    output logic [TXCFG_W-1:0]         tx_cfg,
    output logic                       fc_rx_en,
    output logic                       fc_tx_en,
    output logic                       rx_reset,
    output logic                       tx_reset,
    output logic                       speed_is_100,
    output logic                       speed_is_10_100,
    output logic [DIV_W-1:0]           mdio_div,
    output logic                       mdio_en,
    output logic [MAC_W-1:0]           ucast_addr,
    output logic                       promisc,
    output logic [TBL_DEPTH*MAC_W-1:0] tbl_addrs
);
    localparam int RXSH_W = RXCFG_W + 1;
    localparam int TXSH_W = TXCFG_W + 1;
    localparam logic [RXSH_W-1:0] RXSH_RST = {1'b1, {MAC_W{1'b0}}, 6'b000100};
    localparam logic [TXSH_W-1:0] TXSH_RST = {1'b1, 6'b000100};

    word_sel_e         sel;
    host_words_t       words;
    logic [DATA_W-1:0] rd_word;
    logic              reg_wr, reg_rd, phy_rd;
    logic [RXSH_W-1:0] rx_src, rx_sh;
    logic [TXSH_W-1:0] tx_src, tx_sh;
    logic [1:0]        spd_code;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } bus_state_t;

    bus_state_t bus_d, bus_q;

    assign reg_wr = host_req && !host_phy_sel && !host_op[1];
    assign reg_rd = host_req && !host_phy_sel &&  host_op[1];
    assign phy_rd = host_req &&  host_phy_sel &&  host_op[1];

    mac_cfg_decode u_decode (
        .addr (host_addr),
        .sel  (sel)
    );

    mac_cfg_hostregs #(
        .TBL_DEPTH     (TBL_DEPTH),
        .UCAST_DEFAULT (UCAST_DEFAULT)
    ) u_hostregs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .sel      (sel),
        .wdata    (host_wdata),
        .words    (words),
        .rd_word  (rd_word),
        .tbl_flat (tbl_addrs)
    );

    assign rx_src = {words.fc[FC_RX_BIT], words.rxb[15:0], words.rxa,
                     words.rxb[B_MISC], words.rxb[B_HALF], words.rxb[B_VLAN],
                     words.rxb[B_EN], words.rxb[B_FCS], words.rxb[B_JUMBO]};
    assign tx_src = {words.fc[FC_TX_BIT],
                     words.tx[B_MISC], words.tx[B_HALF], words.tx[B_VLAN],
                     words.tx[B_EN], words.tx[B_FCS], words.tx[B_JUMBO]};

    mac_cfg_shadow #(.W(RXSH_W), .RESET_VAL(RXSH_RST)) u_rx_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (rx_ifg),
        .src    (rx_src),
        .shadow (rx_sh)
    );

    mac_cfg_shadow #(.W(TXSH_W), .RESET_VAL(TXSH_RST)) u_tx_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tx_ifg),
        .src    (tx_src),
        .shadow (tx_sh)
    );

    always_comb begin
        bus_d = bus_q;
        if (reg_rd)      bus_d.rdata = rd_word;
        else if (phy_rd) bus_d.rdata = phy_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_d;
    end

    assign host_rdata = bus_q.rdata;

    assign phy_req   = host_req && host_phy_sel;
    assign phy_op    = host_op;
    assign phy_addr  = host_addr;
    assign phy_wdata = host_wdata;

    assign rx_cfg   = rx_sh[RXCFG_W-1:0];
    assign fc_rx_en = rx_sh[RXSH_W-1];
    assign tx_cfg   = tx_sh[TXCFG_W-1:0];
    assign fc_tx_en = tx_sh[TXSH_W-1];

    assign rx_reset = words.rxb[B_RESET];
    assign tx_reset = words.tx[B_RESET];

    assign spd_code        = words.spd[31:30];
    assign speed_is_100    = (spd_code == SPD_100);
    assign speed_is_10_100 = (spd_code == SPD_100) || (spd_code == SPD_10);

    assign mdio_div   = words.mgmt[DIV_W-1:0];
    assign mdio_en    = words.mgmt[MDIO_EN_BIT];
    assign ucast_addr = {words.ucb[15:0], words.uca};
    assign promisc    = words.afm[PROMISC_BIT];

    AST_SPEED_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
        speed_is_100 |-> speed_is_10_100); // R5

    AST_PHY_LEAVES_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
        host_req && host_phy_sel |=> $stable(words)); // R9

    AST_RX_RESET_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && sel == SEL_RXB |=> rx_reset == $past(host_wdata[B_RESET])); // R8

    AST_TX_RESET_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && sel == SEL_TX |=> tx_reset == $past(host_wdata[B_RESET])); // R8

endmodule

// File: tb/mac_cfg_regbank_test.sv
module mac_cfg_regbank_test;

    localparam logic [47:0] UC_DEF = 48'h0200_0000_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic [1:0]  host_op = 2'b00;
    logic        host_phy_sel = 1'b0;
    logic [9:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        phy_req;
    logic [1:0]  phy_op;
    logic [9:0]  phy_addr;
    logic [31:0] phy_wdata;
    logic [31:0] phy_rdata = 32'h1234_5678;
    logic        rx_ifg = 1'b0;
    logic        tx_ifg = 1'b0;
    logic [53:0] rx_cfg;
    logic [5:0]  tx_cfg;
    logic        fc_rx_en, fc_tx_en, rx_reset, tx_reset;
    logic        speed_is_100, speed_is_10_100;
    logic [5:0]  mdio_div;
    logic        mdio_en;
    logic [47:0] ucast_addr;
    logic        promisc;
    logic [191:0] tbl_addrs;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    mac_cfg_regbank #(.TBL_DEPTH(4), .UCAST_DEFAULT(UC_DEF)) uut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_op(host_op),
        .host_phy_sel(host_phy_sel), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .phy_req(phy_req), .phy_op(phy_op), .phy_addr(phy_addr),
        .phy_wdata(phy_wdata), .phy_rdata(phy_rdata),
        .rx_ifg(rx_ifg), .tx_ifg(tx_ifg), .rx_cfg(rx_cfg), .tx_cfg(tx_cfg),
        .fc_rx_en(fc_rx_en), .fc_tx_en(fc_tx_en), .rx_reset(rx_reset),
        .tx_reset(tx_reset), .speed_is_100(speed_is_100),
        .speed_is_10_100(speed_is_10_100), .mdio_div(mdio_div),
        .mdio_en(mdio_en), .ucast_addr(ucast_addr), .promisc(promisc),
        .tbl_addrs(tbl_addrs)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        host_req = 1'b1; host_op = 2'b00; host_phy_sel = 1'b0;
        host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        host_req = 1'b1; host_op = 2'b10; host_phy_sel = 1'b0; host_addr = a;
        @(negedge clk);
        host_req = 1'b0;
        d = host_rdata;
    endtask

    task automatic pulse_rx_ifg();
        @(negedge clk); rx_ifg = 1'b1;
        @(negedge clk); rx_ifg = 1'b0;
    endtask

    task automatic pulse_tx_ifg();
        @(negedge clk); tx_ifg = 1'b1;
        @(negedge clk); tx_ifg = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        check("R2 rx_cfg", 64'(rx_cfg), 64'h4);
        check("R2 tx_cfg", 64'(tx_cfg), 64'h4);
        check("R2 fc_rx_en", 64'(fc_rx_en), 64'h1);
        check("R2 fc_tx_en", 64'(fc_tx_en), 64'h1);
        check("R2 speed_is_10_100", 64'(speed_is_10_100), 64'h0);
        check("R2 mdio_en", 64'(mdio_en), 64'h0);
        check("R2 promisc", 64'(promisc), 64'h1);
        check("R2 ucast_addr", 64'(ucast_addr), 64'(UC_DEF));
        rd(10'h240, v); check("R2 rx word B", 64'(v), 64'h1000_0000);
        rd(10'h280, v); check("R2 tx word", 64'(v), 64'h1000_0000);
        rd(10'h2C0, v); check("R2 fc word", 64'(v), 64'h6000_0000);
        rd(10'h300, v); check("R2 speed word", 64'(v), 64'h8000_0000);
        rd(10'h340, v); check("R2 mgmt word", 64'(v), 64'h0);
    endtask

    task automatic t_decode();
        logic [31:0] v;
        wr(10'h23F, 32'hA5A5_1234);
        rd(10'h200, v); check("R1 rx word A low", 64'(v), 64'hA5A5_1234);
        rd(10'h21C, v); check("R1 rx word A mid", 64'(v), 64'hA5A5_1234);
        check("R1 rdata holds", 64'(host_rdata), 64'hA5A5_1234);
    endtask

    task automatic t_rx_word();
        logic [31:0] v;
        wr(10'h27C, 32'h7FFF_ABCD);
        rd(10'h240, v); check("R3 rx word B mask", 64'(v), 64'h7E00_ABCD);
        check("R7 rx_cfg before gap", 64'(rx_cfg), 64'h4);
        pulse_tx_ifg();
        check("R7 rx_cfg on tx gap", 64'(rx_cfg), 64'h4);
        pulse_rx_ifg();
        check("R3 rx_cfg after gap", 64'(rx_cfg), {10'd0, 16'hABCD, 32'hA5A5_1234, 6'h3F});
        check("R8 rx_reset clear", 64'(rx_reset), 64'h0);
    endtask

    task automatic t_tx_word();
        logic [31:0] v;
        wr(10'h2A0, 32'h5E00_00FF);
        rd(10'h280, v); check("R4 tx word mask", 64'(v), 64'h5E00_0000);
        check("R7 tx_cfg before gap", 64'(tx_cfg), 64'h4);
        pulse_tx_ifg();
        check("R4 tx_cfg after gap", 64'(tx_cfg), 64'h3D);
    endtask

    task automatic t_flow_speed();
        logic [31:0] v;
        wr(10'h2FC, 32'h5FFF_FFFF);
        rd(10'h2C0, v); check("R5 fc word", 64'(v), 64'h4000_0000);
        check("R7 fc_tx_en before gap", 64'(fc_tx_en), 64'h1);
        pulse_rx_ifg();
        check("R5 fc_rx_en off", 64'(fc_rx_en), 64'h0);
        check("R7 fc_tx_en unchanged by rx gap", 64'(fc_tx_en), 64'h1);
        pulse_tx_ifg();
        check("R5 fc_tx_en on", 64'(fc_tx_en), 64'h1);
        wr(10'h31F, 32'h4000_0000);
        check("R5 100 is100", 64'(speed_is_100), 64'h1);
        check("R5 100 is10100", 64'(speed_is_10_100), 64'h1);
        wr(10'h300, 32'h0);
        check("R5 10 is100", 64'(speed_is_100), 64'h0);
        check("R5 10 is10100", 64'(speed_is_10_100), 64'h1);
        wr(10'h300, 32'hFFFF_FFFF);
        rd(10'h310, v); check("R5 code 11 read", 64'(v), 64'hC000_0000);
        check("R5 code 11 is10100", 64'(speed_is_10_100), 64'h0);
        wr(10'h300, 32'h8000_0000);
        check("R5 1000 is100", 64'(speed_is_100), 64'h0);
        check("R5 1000 is10100", 64'(speed_is_10_100), 64'h0);
    endtask

    task automatic t_mgmt();
        logic [31:0] v;
        wr(10'h37C, 32'hFFFF_FFEB);
        rd(10'h340, v); check("R6 mgmt word", 64'(v), 64'h6B);
        check("R6 mdio_div", 64'(mdio_div), 64'h2B);
        check("R6 mdio_en", 64'(mdio_en), 64'h1);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        wr(10'h320, 32'hFFFF_FFFF);
        wr(10'h100, 32'hFFFF_FFFF);
        wr(10'h3C4, 32'hFFFF_FFFF);
        rd(10'h33F, v); check("R10 reserved reads 0", 64'(v), 64'h0);
        rd(10'h100, v); check("R10 low unmapped reads 0", 64'(v), 64'h0);
        rd(10'h3FC, v); check("R10 high unmapped reads 0", 64'(v), 64'h0);
        rd(10'h300, v); check("R10 speed untouched", 64'(v), 64'h8000_0000);
        rd(10'h340, v); check("R10 mgmt untouched", 64'(v), 64'h6B);
    endtask

    task automatic t_reset_bits();
        logic [31:0] v;
        wr(10'h240, 32'h8000_0000);
        check("R8 rx_reset at once", 64'(rx_reset), 64'h1);
        check("R8 tx_reset unaffected", 64'(tx_reset), 64'h0);
        check("R7 rx_cfg kept during reset", 64'(rx_cfg), {10'd0, 16'hABCD, 32'hA5A5_1234, 6'h3F});
        wr(10'h280, 32'h8000_0000);
        check("R8 tx_reset at once", 64'(tx_reset), 64'h1);
        rd(10'h240, v); check("R8 rx word B read", 64'(v), 64'h8000_0000);
        wr(10'h240, 32'h1000_0000);
        wr(10'h280, 32'h1000_0000);
        check("R8 rx_reset released", 64'(rx_reset), 64'h0);
        check("R8 tx_reset released", 64'(tx_reset), 64'h0);
    endtask

    task automatic t_phy();
        logic [31:0] v;
        @(negedge clk);
        host_req = 1'b1; host_op = 2'b01; host_phy_sel = 1'b1;
        host_addr = 10'h240; host_wdata = 32'h8000_DEAD;
        #1;
        check("R9 phy_req", 64'(phy_req), 64'h1);
        check("R9 phy_addr", 64'(phy_addr), 64'h240);
        check("R9 phy_wdata", 64'(phy_wdata), 64'h8000_DEAD);
        check("R9 phy_op", 64'(phy_op), 64'h1);
        @(negedge clk);
        host_req = 1'b0; host_phy_sel = 1'b0;
        check("R9 rx_reset untouched", 64'(rx_reset), 64'h0);
        rd(10'h240, v); check("R9 rx word B untouched", 64'(v), 64'h1000_0000);
        @(negedge clk);
        host_req = 1'b1; host_op = 2'b10; host_phy_sel = 1'b0; host_addr = 10'h240;
        #1;
        check("R9 phy_req low on register access", 64'(phy_req), 64'h0);
        @(negedge clk);
        host_req = 1'b1; host_op = 2'b10; host_phy_sel = 1'b1;
        @(negedge clk);
        host_req = 1'b0; host_phy_sel = 1'b0;
        check("R9 phy read data", 64'(host_rdata), 64'h1234_5678);
    endtask

    task automatic t_table();
        logic [31:0] v;
        wr(10'h388, 32'h1122_3344);
        wr(10'h38C, 32'h0002_5566);
        wr(10'h389, 32'hAAAA_AAAA);
        wr(10'h38F, 32'h0001_7788);
        check("R11 entry 2", 64'(tbl_addrs[96 +: 48]), 64'h5566_1122_3344);
        check("R11 entry 1", 64'(tbl_addrs[48 +: 48]), 64'h7788_AAAA_AAAA);
        check("R11 entry 0 empty", 64'(tbl_addrs[0 +: 48]), 64'h0);
        wr(10'h38C, 32'h0082_0000);
        rd(10'h388, v); check("R11 readback low", 64'(v), 64'h1122_3344);
        rd(10'h38C, v); check("R11 readback high", 64'(v), 64'h0002_5566);
        check("R11 entry 2 kept", 64'(tbl_addrs[96 +: 48]), 64'h5566_1122_3344);
    endtask

    task automatic t_ucast();
        logic [31:0] v;
        wr(10'h380, 32'hCAFE_BABE);
        wr(10'h387, 32'hFFFF_0102);
        rd(10'h384, v); check("R12 ucast word B", 64'(v), 64'h0102);
        check("R12 ucast_addr", 64'(ucast_addr), 64'h0102_CAFE_BABE);
        wr(10'h3B4, 32'h7FFF_FFFF);
        check("R12 promisc off", 64'(promisc), 64'h0);
        rd(10'h390, v); check("R12 filter word", 64'(v), 64'h0);
        wr(10'h391, 32'h8000_0000);
        check("R12 promisc on", 64'(promisc), 64'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_decode();
        t_rx_word();
        t_tx_word();
        t_flow_speed();
        t_mgmt();
        t_reserved();
        t_reset_bits();
        t_phy();
        t_table();
        t_ucast();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule